// File: doc/BRIEF.md
# Paired-Spare Permutation Switch for a Unit Cluster

This block routes data between six functional lanes and a cluster of eight identical processing units, two of which are always held in reserve. A two-bit configuration word selects which adjacent pair of units is taken out of service. The six remaining units are assigned to the lanes in ascending unit order. The two excluded units have their data inputs held at zero, and their results are brought out on two observation outputs so that a diagnostic routine can see them.

Stepping through the four configurations places every unit on the observation outputs exactly once. This lets a self-test locate a faulty unit and then choose a configuration that keeps it out of the functional path. Any single failed unit can be masked this way, and so can two failures that fall inside the same pair. Each unit is a parameterised generic function with a per-bit stuck-at injection mask, so the repair behaviour can be exercised. The configuration word is captured in a register. The data path from lanes to units and back is purely combinational.

Top module: `spare_permute_switch`

## Requirements
- R1: While `rst_n` is low, the captured configuration is 0, so units 0 and 1 are excluded whatever `cfg_sel` carries.
- R2: `cfg_sel` is captured on every rising clock edge. A new selection changes the routing only after that edge, and the old routing holds until then.
- R3: With configuration s (0..3), units 2s and 2s+1 are excluded. Lane slice l (bits l*8 +: 8) of `lane_in` and `lane_out` belongs to unit l when l < 2s, and to unit l+2 otherwise.
- R4: Both excluded units receive an all-zero data input, whatever `lane_in` carries.
- R5: Slice k (k = 0, 1) of `obs_out` carries the output of unit 2s+k.
- R6: A healthy unit computes y = (x + 8'h5A) XOR {x[0], x[7:1]}, modulo 256. For every bit set in that unit's slice of `flt_mask` (unit u uses bits u*8 +: 8), the output bit takes the matching bit of `flt_val` instead.
- R7: Faults injected only into units 2s and/or 2s+1 never change `lane_out` in configuration s. This covers every single fault and every double fault within one pair.
- R8: A fault injected into an excluded unit is visible on `obs_out`.
- R9: `lane_out` follows a change of `lane_in` within the same clock cycle, with no clock edge in between.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the configuration register |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_sel | input | 2 | Requested configuration (excluded pair index) |
| lane_in | input | 48 | Six 8-bit functional lane inputs, lane 0 in the low bits |
| flt_mask | input | 64 | Per-unit stuck-at enable bits, unit 0 in the low byte |
| flt_val | input | 64 | Per-unit stuck-at values |
| lane_out | output | 48 | Six 8-bit functional lane results |
| obs_out | output | 16 | Results of the two excluded units, lower unit in the low byte |

## Verification
The bench places a stuck-at fault on each unit in turn, and also on both units of one pair, and selects the matching configuration. A lane map that is off by one at the pair boundary, for example lane 2s taken from unit 2s, would then put a faulty result on a functional lane. An inverted or missing input ground would show as lane data leaking to the observation outputs, and the bench checks this across varied lane patterns. The bench also drives new lane data and a new selection together between edges. This exposes a design that registers the data path, or one that applies the selection before the clock edge. It also runs one configuration that does not match the fault, to show that the injected fault is really active.

// File: rtl/spr_pkg.sv
`timescale 1ns/1ps
package spr_pkg;
   typedef enum logic [0:0] {
      FN_MIXROT = 1'b0,
      FN_NEGADD = 1'b1
   } spr_fn_e;
endpackage

// File: rtl/spr_cfg_reg.sv
`timescale 1ns/1ps
module spr_cfg_reg #(
   parameter int SW = 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [SW-1:0] sel_i,
   output logic [SW-1:0] state_o
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state_o <= '0;
      else        state_o <= sel_i;
   end

   // R1: reset forces configuration zero
   a_r1_reset_state: assert property (@(posedge clk)
      !rst_n |=> (state_o == '0));

   // R2: captured value is the selection seen at the previous edge
   a_r2_follows_sel: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) |-> (state_o == $past(sel_i)));
endmodule

// File: rtl/spr_unit.sv
`timescale 1ns/1ps
module spr_unit
   import spr_pkg::*;
#(
   parameter int           W   = 8,
   parameter logic [W-1:0] KEY = 8'h5A,
   parameter spr_fn_e      FN  = FN_MIXROT
) (
   input  logic [W-1:0] x_i,
   input  logic [W-1:0] mask_i,
   input  logic [W-1:0] val_i,
   output logic [W-1:0] y_o
);
   logic [W-1:0] good;

   generate
      if (W < 2) begin : g_bad_width
         $error("spr_unit: W must be at least 2");
      end
      if (FN == FN_MIXROT) begin : g_mixrot
         always_comb good = (x_i + KEY) ^ {x_i[0], x_i[W-1:1]};
      end else begin : g_negadd
         always_comb good = (~x_i) + KEY;
      end
   endgenerate

   // stuck-at injection: masked bits take the forced value
   always_comb y_o = (good & ~mask_i) | (val_i & mask_i);
endmodule

// File: rtl/spr_in_router.sv
`timescale 1ns/1ps
module spr_in_router #(
   parameter int W  = 8,
   parameter int NU = 8,
   parameter int SP = 2,
   parameter int NL = NU - SP,
   parameter int SW = 2
) (
   input  logic [SW-1:0]   state_i,
   input  logic [NL*W-1:0] lane_i,
   output logic [NU*W-1:0] unit_o
);
   generate
      for (genvar u = 0; u < NU; u++) begin : g_unit
         localparam int PAIR = u / SP;
         localparam int LO   = (u < NL)  ? u      : 0;
         localparam int HI   = (u >= SP) ? u - SP : 0;
         always_comb begin
            if (int'(state_i) == PAIR)
               unit_o[u*W +: W] = '0;
            else if (u < SP * int'(state_i))
               unit_o[u*W +: W] = lane_i[LO*W +: W];
            else
               unit_o[u*W +: W] = lane_i[HI*W +: W];
         end
      end
   endgenerate
endmodule

// File: rtl/spr_out_router.sv
`timescale 1ns/1ps
module spr_out_router #(
   parameter int W  = 8,
   parameter int NU = 8,
   parameter int SP = 2,
   parameter int NL = NU - SP,
   parameter int NS = NU / SP,
   parameter int SW = 2
) (
   input  logic [SW-1:0]   state_i,
   input  logic [NU*W-1:0] unit_i,
   output logic [NL*W-1:0] lane_o,
   output logic [SP*W-1:0] obs_o
);
   generate
      for (genvar l = 0; l < NL; l++) begin : g_lane
         always_comb begin
            if (l < SP * int'(state_i))
               lane_o[l*W +: W] = unit_i[l*W +: W];
            else
               lane_o[l*W +: W] = unit_i[(l+SP)*W +: W];
         end
      end
   endgenerate

   always_comb begin
      obs_o = '0;
      for (int s = 0; s < NS; s++) begin
         if (int'(state_i) == s) obs_o = unit_i[s*SP*W +: SP*W];
      end
   end
endmodule

// File: rtl/spare_permute_switch.sv
`timescale 1ns/1ps
module spare_permute_switch
   import spr_pkg::*;
#(
   parameter int           W      = 8,
   parameter int           NU     = 8,
   parameter int           SP     = 2,
   parameter logic [W-1:0] KEY    = 8'h5A,
   parameter spr_fn_e      FN     = FN_MIXROT,
   parameter int           NL     = NU - SP,
   parameter int           NS     = NU / SP,
   parameter int           SW     = (NS > 1) ? $clog2(NS) : 1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [SW-1:0]   cfg_sel,
   input  logic [NL*W-1:0] lane_in,
   input  logic [NU*W-1:0] flt_mask,
   input  logic [NU*W-1:0] flt_val,
   output logic [NL*W-1:0] lane_out,
   output logic [SP*W-1:0] obs_out
);
   generate
      if (SP < 1 || NU % SP != 0 || NU / SP < 2) begin : g_bad_geometry
         $error("spare_permute_switch: NU must be a multiple of SP with at least two groups");
      end
      if ((1 << SW) < NS) begin : g_bad_sw
         $error("spare_permute_switch: SW too narrow for NS");
      end
   endgenerate

   logic [SW-1:0]   state_q;
   logic [NU*W-1:0] unit_in_w;
   logic [NU*W-1:0] unit_out_w;

   spr_cfg_reg #(.SW(SW)) u_cfg (
      .clk(clk), .rst_n(rst_n), .sel_i(cfg_sel), .state_o(state_q)
   );

   spr_in_router #(.W(W), .NU(NU), .SP(SP), .NL(NL), .SW(SW)) u_inr (
      .state_i(state_q), .lane_i(lane_in), .unit_o(unit_in_w)
   );

   generate
      for (genvar u = 0; u < NU; u++) begin : g_units
         spr_unit #(.W(W), .KEY(KEY), .FN(FN)) u_unit (
            .x_i   (unit_in_w[u*W +: W]),
            .mask_i(flt_mask[u*W +: W]),
            .val_i (flt_val[u*W +: W]),
            .y_o   (unit_out_w[u*W +: W])
         );
      end
   endgenerate

   spr_out_router #(.W(W), .NU(NU), .SP(SP), .NL(NL), .NS(NS), .SW(SW)) u_outr (
      .state_i(state_q), .unit_i(unit_out_w), .lane_o(lane_out), .obs_o(obs_out)
   );

   // R4: excluded pair is grounded at its inputs
   a_r4_spares_grounded: assert property (@(posedge clk) disable iff (!rst_n)
      unit_in_w[int'(state_q)*SP*W +: SP*W] == '0);

   // R5: observation outputs carry the excluded pair
   a_r5_obs_from_spares: assert property (@(posedge clk) disable iff (!rst_n)
      obs_out == unit_out_w[int'(state_q)*SP*W +: SP*W]);

   // R3: each lane reaches its unit and returns from the same unit
   generate
      for (genvar l = 0; l < NL; l++) begin : g_chk
         a_r3_lane_map: assert property (@(posedge clk) disable iff (!rst_n)
            (l < SP*int'(state_q))
               ? (unit_in_w[l*W +: W] == lane_in[l*W +: W] &&
                  lane_out[l*W +: W] == unit_out_w[l*W +: W])
               : (unit_in_w[(l+SP)*W +: W] == lane_in[l*W +: W] &&
                  lane_out[l*W +: W] == unit_out_w[(l+SP)*W +: W]));
      end
   endgenerate

   // R9: with all inputs and state steady, lanes do not move
   a_r9_steady_out: assert property (@(posedge clk) disable iff (!rst_n)
      ($stable(state_q) && $stable(lane_in) && $stable(flt_mask) && $stable(flt_val))
         |-> $stable(lane_out));
endmodule

// File: tb/sim_spare_permute_switch.sv
`timescale 1ns/1ps
module sim_spare_permute_switch;
   localparam int W  = 8;
   localparam int NU = 8;
   localparam int SP = 2;
   localparam int NL = 6;
   localparam logic [7:0] KEY = 8'h5A;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic [1:0]      cfg_sel = 2'd3;
   logic [NL*W-1:0] lane_in = '0;
   logic [NU*W-1:0] flt_mask = '0;
   logic [NU*W-1:0] flt_val = '0;
   logic [NL*W-1:0] lane_out;
   logic [SP*W-1:0] obs_out;

   int    n_checks = 0;
   int    n_fail = 0;
   bit    started = 0;
   bit    done = 0;
   string lane_tag = "R1";
   string obs_tag = "R1";
   int    m_state = 0;

   always #10 clk = ~clk;   // 50 MHz

   spare_permute_switch u0 (
      .clk(clk), .rst_n(rst_n), .cfg_sel(cfg_sel), .lane_in(lane_in),
      .flt_mask(flt_mask), .flt_val(flt_val), .lane_out(lane_out), .obs_out(obs_out)
   );

   // behavioural model of the configuration capture
   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) m_state <= 0;
      else        m_state <= int'(cfg_sel);
   end

   function automatic logic [7:0] ufn(logic [7:0] x, logic [7:0] m, logic [7:0] v);
      logic [7:0] y;
      y = (x + KEY) ^ {x[0], x[7:1]};
      return (y & ~m) | (v & m);
   endfunction

   task automatic check(string tag, string what, logic [7:0] act, logic [7:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s actual %h expected %h", tag, what, act, exp);
      end
   endtask

   task automatic compare_all(string ltag, string otag);
      int         ord[$];
      logic [7:0] ux [NU];
      logic [7:0] uy [NU];
      for (int u = 0; u < NU; u++) begin
         ux[u] = 8'h00;
         if (u / SP != m_state) ord.push_back(u);
      end
      for (int i = 0; i < ord.size(); i++) ux[ord[i]] = lane_in[i*W +: W];
      for (int u = 0; u < NU; u++)
         uy[u] = ufn(ux[u], flt_mask[u*W +: W], flt_val[u*W +: W]);
      for (int i = 0; i < NL; i++)
         check(ltag, $sformatf("lane %0d state %0d", i, m_state), lane_out[i*W +: W], uy[ord[i]]);
      for (int k = 0; k < SP; k++)
         check(otag, $sformatf("obs %0d state %0d", k, m_state), obs_out[k*W +: W], uy[m_state*SP + k]);
   endtask

   // compare on every clock, away from the edge
   always @(posedge clk) begin
      #5;
      if (started && !done) compare_all(lane_tag, obs_tag);
   end

   task automatic drive(logic [1:0] s, logic [NL*W-1:0] li);
      @(negedge clk);
      cfg_sel = s;
      lane_in = li;
   endtask

   task automatic set_fault(int u, logic [7:0] m, logic [7:0] v);
      flt_mask[u*W +: W] = m;
      flt_val[u*W +: W]  = v;
   endtask

   initial begin
      #(20 * 100000);
      n_checks++;
      n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

   initial begin
      lane_in = 48'h0605_0403_0201;
      started = 1;
      // R1: reset holds configuration 0 despite cfg_sel = 3
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R3 / R5 / R2: sweep configurations with several lane patterns
      lane_tag = "R3"; obs_tag = "R5";
      for (int s = 0; s < 4; s++) begin
         drive(2'(s), 48'h0123_4567_89AB);
         drive(2'(s), 48'hFFEE_DDCC_BBAA);
         drive(2'(s), 48'h8001_7F80_00FF);
      end

      // R9 and R2: new data and new selection between edges
      lane_tag = "R9"; obs_tag = "R2";
      for (int s = 3; s >= 0; s--) begin
         drive(2'(s), 48'hA5C3_0F1E_2D3C + 48'(s));
         #3 compare_all("R9", "R2");   // routing still old, data already new
      end

      // R4: excluded inputs grounded whatever the lanes carry
      lane_tag = "R3"; obs_tag = "R4";
      for (int p = 0; p < 6; p++) drive(2'd1, {8{6'(p * 11 + 5)}});

      // R7 / R8: single stuck-at faults masked by the matching configuration
      lane_tag = "R7"; obs_tag = "R8";
      for (int u = 0; u < NU; u++) begin
         flt_mask = '0; flt_val = '0;
         set_fault(u, 8'hFF, 8'hFF);
         drive(2'(u / SP), 48'h1122_3344_5566);
         drive(2'(u / SP), 48'h99AA_BBCC_DDEE);
         flt_mask = '0; flt_val = '0;
         set_fault(u, 8'h0F, 8'h00);
         drive(2'(u / SP), 48'h7777_3333_FFFF);
      end

      // R7: double fault within one pair
      flt_mask = '0; flt_val = '0;
      set_fault(4, 8'hFF, 8'h00);
      set_fault(5, 8'hF0, 8'hA0);
      drive(2'd2, 48'h0F0F_F0F0_1234);
      drive(2'd2, 48'hCAFE_BABE_0042);

      // R6: mismatched configuration, fault reaches a lane per the model
      lane_tag = "R6"; obs_tag = "R6";
      flt_mask = '0; flt_val = '0;
      set_fault(0, 8'hFF, 8'h3C);
      drive(2'd3, 48'h0000_0000_0011);
      drive(2'd3, 48'h1357_9BDF_2468);
      flt_mask = '0; flt_val = '0;
      drive(2'd0, 48'h0000_0000_0000);
      @(negedge clk);
      done = 1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end
endmodule